// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This unit is the integer datapath stage of a load/store processor core. On every cycle it receives two 32-bit operands, an operation code, a flag-write request and a 22-bit upper constant. It returns a combinational 32-bit result in the same cycle. It also keeps a four-bit condition register that the branch logic downstream reads directly.

The unit supports addition and subtraction, and each can also consume the stored carry to chain multi-word arithmetic. It supports three bitwise operations: AND, OR, and OR with the second operand inverted. A compare operation updates the flags and produces no result. A final operation builds a word from the upper constant. The flags change only when the caller asks for it, or when the operation is a compare. Any flag change becomes visible after the next rising clock edge. An operation that directly follows can therefore chain on the new carry.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-low reset clears all four flags to 0. `flags_o` is ordered {N, Z, V, C}, bit 3 down to bit 0.
- R2: When `set_flags_i` is 0 and the operation is not compare, the flags keep their value across the clock edge.
- R3: On a flag-writing operation, Z becomes 1 exactly when the 32-bit outcome is zero.
- R4: On a flag-writing operation, N becomes bit 31 of the outcome.
- R5: On flag-writing additions, C becomes the carry out of bit 31.
- R6: On flag-writing subtractions and compare, C becomes the borrow. The borrow is 1 when the unsigned first operand is below the unsigned second operand, plus the borrow-in for the borrow variant.
- R7: On flag-writing arithmetic, V becomes 1 exactly when the signed outcome does not fit in 32 bits.
- R8: Add-with-carry computes a+b+C and subtract-with-borrow computes a-b-C, where C is the stored flag. A flag update from the previous cycle is used by the next operation.
- R9: AND, OR and OR-NOT (a | ~b) produce their bitwise result. Their flag-writing variants clear V and C.
- R10: Compare drives `result_o` to zero and always writes all four flags as for a-b, whatever the value of `set_flags_i`.
- R11: The upper-constant operation outputs the 22-bit constant in bits 31:10 and zeros in bits 9:0. It never changes the flags.
- R12: The operation codes are 0 add, 1 sub, 2 add-with-carry, 3 subtract-with-borrow, 4 AND, 5 OR, 6 OR-NOT, 7 compare, 8 upper constant. Codes 9 to 15 output zero and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request to write the flags |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| const_i | input | 22 | Upper constant |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Condition register {N, Z, V, C} |

## Verification
The hardest case to reach is a carry-chained operation whose outcome depends on a carry written in the cycle just before. It is also hard to show that flag-neutral operations placed between the writer and the reader leave that carry intact. The vector table is ordered so that each carry-consuming row follows a row that sets or clears C. Non-writing variants are placed between them, and every row's expected flags follow from the history of the rows before it. Directed cases then apply reset in the middle of a sequence, and send an unused operation code with the flag request raised while the flags are non-zero.

// File: rtl/int_exec_pkg.sv
// Package: shared operation codes and flag layout for the integer execution unit.
// Assumes: the flag vector is ordered {N, Z, V, C} from bit 3 down to bit 0.
package int_exec_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_ADDC  = 4'd2,
        OP_SUBB  = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_ORN   = 4'd6,
        OP_CMP   = 4'd7,
        OP_UPPER = 4'd8
    } exec_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } cond_flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/exec_arith.sv
// Module: adder/subtractor slice.
// Computes a + b + cin or a - b - cin through one shared adder.
// Reports the carry for additions and the borrow for subtractions,
// plus the signed overflow. Assumes two's complement operands.
module exec_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              use_cin_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              carry_o,
    output logic              ovf_o
);
    localparam int WIDE_W = DATA_W + 1;

    logic [DATA_W-1:0] b_eff;
    logic              c_in_eff;
    logic [WIDE_W-1:0] wide_sum;

    // Invert the second operand and the carry-in for subtraction.
    always_comb begin
        b_eff    = sub_i ? ~b_i : b_i;
        c_in_eff = sub_i ? ~(use_cin_i & cin_i) : (use_cin_i & cin_i);
    end

    // One adder, then carry/borrow and overflow derivation.
    always_comb begin
        wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_in_eff};
        sum_o    = wide_sum[DATA_W-1:0];
        carry_o  = sub_i ? ~wide_sum[DATA_W] : wide_sum[DATA_W];
        ovf_o    = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
                   (wide_sum[DATA_W-1] != a_i[DATA_W-1]);
    end

endmodule

// File: rtl/exec_logic.sv
// Module: bitwise slice and upper-constant builder.
// Produces AND, OR, OR-NOT (a | ~b) and the constant placed in the top bits.
// Assumes CONST_W < DATA_W. Unlisted selects return zero.
module exec_logic #(
    parameter int DATA_W  = 32,
    parameter int CONST_W = 22
) (
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [CONST_W-1:0] k_i,
    input  logic [3:0]         op_i,
    output logic [DATA_W-1:0]  res_o
);
    import int_exec_pkg::*;

    localparam int LOW_W = DATA_W - CONST_W;

    logic [DATA_W-1:0] upper_word;

    // Place the constant in the upper bits and zero-fill the low part.
    always_comb upper_word = {k_i, {LOW_W{1'b0}}};

    // Pick the bitwise or constant outcome.
    always_comb begin
        unique case (op_i)
            OP_AND:   res_o = a_i & b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_ORN:   res_o = a_i | ~b_i;
            OP_UPPER: res_o = upper_word;
            default:  res_o = '0;
        endcase
    end

endmodule

// File: rtl/exec_flags.sv
// Module: condition flag register.
// Loads the next flags when upd_i is high and holds them otherwise.
// Assumes a synchronous active-low reset that clears every flag.
module exec_flags
    import int_exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        upd_i,
    input  cond_flags_t next_i,
    output cond_flags_t flags_o
);
    cond_flags_t flags_q;

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags_q <= '0;
        else if (upd_i) flags_q <= next_i;
    end

    always_comb flags_o = flags_q;

    // R2: without an update request the stored flags do not move.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> flags_o == $past(flags_o));

endmodule

// File: rtl/int_exec_unit.sv
// Module: top of the integer execution unit.
// Decodes the operation, routes the operands to the arithmetic and bitwise
// slices, forms the result and the next flags, and keeps the condition register.
// Assumes operands are already read and extended by the caller.
module int_exec_unit #(
    parameter int DATA_W  = 32,
    parameter int CONST_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         op_i,
    input  logic               set_flags_i,
    input  logic [DATA_W-1:0]  opa_i,
    input  logic [DATA_W-1:0]  opb_i,
    input  logic [CONST_W-1:0] const_i,
    output logic [DATA_W-1:0]  result_o,
    output logic [3:0]         flags_o
);
    import int_exec_pkg::*;

    localparam int LOW_W = DATA_W - CONST_W;

    logic              is_arith, is_sub, use_cin, is_logic, is_cmp, upd;
    logic [DATA_W-1:0] arith_sum, logic_res, raw_res;
    logic              arith_carry, arith_ovf;
    cond_flags_t       cur_flags, next_flags;

    // Decode the operation code into slice controls.
    always_comb begin
        is_arith = 1'b0;
        is_sub   = 1'b0;
        use_cin  = 1'b0;
        is_logic = 1'b0;
        is_cmp   = 1'b0;
        unique case (op_i)
            OP_ADD:  is_arith = 1'b1;
            OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; end
            OP_ADDC: begin is_arith = 1'b1; use_cin = 1'b1; end
            OP_SUBB: begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; end
            OP_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; is_cmp = 1'b1; end
            OP_AND, OP_OR, OP_ORN: is_logic = 1'b1;
            default: ;
        endcase
        upd = is_cmp | (set_flags_i & (is_arith | is_logic));
    end

    exec_arith #(.DATA_W(DATA_W)) arith_i (
        .a_i       (opa_i),
        .b_i       (opb_i),
        .sub_i     (is_sub),
        .use_cin_i (use_cin),
        .cin_i     (cur_flags.carry),
        .sum_o     (arith_sum),
        .carry_o   (arith_carry),
        .ovf_o     (arith_ovf)
    );

    exec_logic #(.DATA_W(DATA_W), .CONST_W(CONST_W)) logic_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .k_i   (const_i),
        .op_i  (op_i),
        .res_o (logic_res)
    );

    // Merge slice outputs; compare suppresses the visible result.
    always_comb begin
        raw_res  = is_arith ? arith_sum : logic_res;
        result_o = is_cmp ? '0 : raw_res;
    end

    // Build the candidate flags from the merged outcome.
    always_comb begin
        next_flags.neg   = raw_res[DATA_W-1];
        next_flags.zero  = (raw_res == '0);
        next_flags.ovf   = is_arith ? arith_ovf   : 1'b0;
        next_flags.carry = is_arith ? arith_carry : 1'b0;
    end

    exec_flags flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (upd),
        .next_i  (next_flags),
        .flags_o (cur_flags)
    );

    always_comb flags_o = cur_flags;

    // R2 and R12: non-writing and unused operations leave the flags alone.
    assert_keep_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != OP_CMP && (!set_flags_i || op_i > OP_UPPER)) |=> $stable(flags_o));

    // R3: a written Z reflects whether the outcome was zero.
    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flags_o[2] == $past(raw_res == '0));

    // R4: a written N copies the outcome sign.
    assert_neg_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flags_o[3] == $past(raw_res[DATA_W-1]));

    // R9: flag-writing bitwise operations clear V and C.
    assert_logic_vc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_ORN))
        |=> flags_o[1:0] == 2'b00);

    // R10: compare shows a zero result.
    assert_cmp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CMP |-> result_o == '0);

    // R11: the upper-constant word has a clear low part.
    assert_upper_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_UPPER |-> result_o[LOW_W-1:0] == '0);

endmodule

// File: tb/int_exec_unit_tb_top.sv
// Bench: walks a vector table in order, so flags carry over between rows,
// then runs directed reset, unused-code and carry-chain cases.
module int_exec_unit_tb_top;

    typedef struct packed {
        logic [3:0]  op;
        logic        sf;
        logic [31:0] a;
        logic [31:0] b;
        logic [21:0] k;
        logic [31:0] res;
        logic [3:0]  fl;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 1'b0, 32'h0000_0001, 32'h0000_0002, 22'h0, 32'h0000_0003, 4'b0000},
        '{4'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 22'h0, 32'h0000_0000, 4'b0101},
        '{4'd2, 1'b0, 32'h0000_0005, 32'h0000_0006, 22'h0, 32'h0000_000C, 4'b0101},
        '{4'd2, 1'b1, 32'h7FFF_FFFF, 32'h0000_0000, 22'h0, 32'h8000_0000, 4'b1010},
        '{4'd1, 1'b1, 32'h0000_0003, 32'h0000_0005, 22'h0, 32'hFFFF_FFFE, 4'b1001},
        '{4'd3, 1'b1, 32'h0000_000A, 32'h0000_0003, 22'h0, 32'h0000_0006, 4'b0000},
        '{4'd3, 1'b0, 32'h0000_000A, 32'h0000_0003, 22'h0, 32'h0000_0007, 4'b0000},
        '{4'd1, 1'b1, 32'h8000_0000, 32'h0000_0001, 22'h0, 32'h7FFF_FFFF, 4'b0010},
        '{4'd4, 1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 22'h0, 32'hF000_F000, 4'b0010},
        '{4'd4, 1'b1, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 22'h0, 32'h0000_0000, 4'b0100},
        '{4'd5, 1'b1, 32'h8000_0000, 32'h0000_0001, 22'h0, 32'h8000_0001, 4'b1000},
        '{4'd6, 1'b0, 32'h0000_0000, 32'hFFFF_0000, 22'h0, 32'h0000_FFFF, 4'b1000},
        '{4'd6, 1'b1, 32'h1234_0000, 32'hFFFF_FFFF, 22'h0, 32'h1234_0000, 4'b0000},
        '{4'd7, 1'b0, 32'h0000_0005, 32'h0000_0005, 22'h0, 32'h0000_0000, 4'b0100},
        '{4'd7, 1'b1, 32'h0000_0002, 32'h0000_0007, 22'h0, 32'h0000_0000, 4'b1001},
        '{4'd8, 1'b1, 32'h0000_0000, 32'h0000_0000, 22'h3FFFFF, 32'hFFFF_FC00, 4'b1001},
        '{4'd8, 1'b0, 32'hDEAD_BEEF, 32'h0000_0000, 22'h12345, 32'h048D_1400, 4'b1001},
        '{4'd3, 1'b1, 32'h0000_0000, 32'h0000_0000, 22'h0, 32'hFFFF_FFFF, 4'b1001},
        '{4'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, 22'h0, 32'h0000_0000, 4'b0111},
        '{4'd2, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 22'h0, 32'hFFFF_FFFF, 4'b1001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic        set_flags_i = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_i = '0;
    logic [21:0] const_i = '0;
    logic [31:0] result_o;
    logic [3:0]  flags_o;

    int  n_checks = 0;
    int  n_bad    = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    int_exec_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .set_flags_i (set_flags_i),
        .opa_i       (opa_i),
        .opb_i       (opb_i),
        .const_i     (const_i),
        .result_o    (result_o),
        .flags_o     (flags_o)
    );

    function automatic string res_tag(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return "R5/R6 result";
            4'd2, 4'd3:       return "R8 result";
            4'd4, 4'd5, 4'd6: return "R9 result";
            4'd7:             return "R10 result";
            4'd8:             return "R11 result";
            default:          return "R12 result";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_bad);
    endtask

    // Apply one operation at the falling edge, check the result, then the flags after the edge.
    task automatic apply(input logic [3:0] op, input logic sf, input logic [31:0] a,
                         input logic [31:0] b, input logic [21:0] k,
                         input logic [31:0] eres, input logic [3:0] efl, input string tag);
        @(negedge clk);
        op_i = op; set_flags_i = sf; opa_i = a; opb_i = b; const_i = k;
        #1 check(tag, result_o, eres);
        @(posedge clk);
        #1 check("R2/R3/R4/R5/R6/R7 flags", {28'h0, flags_o}, {28'h0, efl});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 reset flags", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].sf, VECS[i].a, VECS[i].b, VECS[i].k,
                  VECS[i].res, VECS[i].fl, res_tag(VECS[i].op));
        end

        // R1: reset in mid-sequence wins over a flag-writing operation.
        @(negedge clk);
        rst_n = 1'b0;
        op_i = 4'd0; set_flags_i = 1'b1; opa_i = 32'hFFFF_FFFF; opb_i = 32'h1;
        @(posedge clk);
        #1 check("R1 mid-run reset", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: unused code outputs zero and keeps non-zero flags.
        apply(4'd0, 1'b1, 32'hFFFF_FFFF, 32'h1, 22'h0, 32'h0, 4'b0101, "R5 result");
        apply(4'd15, 1'b1, 32'h1234_5678, 32'h1, 22'h3FF, 32'h0, 4'b0101, "R12 unused code");
        apply(4'd9, 1'b1, 32'hFFFF_FFFF, 32'h0, 22'h1, 32'h0, 4'b0101, "R12 unused code");

        // R8: carry set above survives, then feeds add-with-carry.
        apply(4'd2, 1'b0, 32'h0, 32'h0, 22'h0, 32'h1, 4'b0101, "R8 chained carry");
        // R8: borrow variant with stored carry set.
        apply(4'd3, 1'b1, 32'h0000_0005, 32'h0000_0005, 22'h0, 32'hFFFF_FFFF, 4'b1001, "R8 chained borrow");
        // R10: compare writes flags even with set_flags_i low (3 vs 1: no borrow).
        apply(4'd7, 1'b0, 32'h3, 32'h1, 22'h0, 32'h0, 4'b0000, "R10 compare");

        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule